// File: doc/BRIEF.md
# Stereo Serial Audio Serializer/Deserializer

This block moves stereo PCM between a parallel sample interface and a two-wire serial audio link. It shifts left and right samples out on a serial data output and captures them from a serial data input. Bit timing comes from an external bit strobe, a one-cycle pulse per bit period, and channel timing comes from an external word-select level that is sampled on each strobe. Clock generation, FIFOs and DMA are outside the block.

Three framings are supported. In standard I2S the word starts one bit after the word-select change. In MSB-justified framing the word starts on the change. In LSB-justified framing the word ends on the last bit of the half-frame. The word-select polarity, the sample length and the frame length are all selectable. Samples shorter than the half-frame slot are padded. Samples longer than the slot keep only their top bits. A direction select chooses transmit, receive, both or neither. Each direction exchanges one stereo pair at a time through a valid/ready handshake.

Top module: `i2s_serdes`

## Requirements
- R1: After reset, sd_out, rx_valid and tx_underrun are 0. tx_ready is 1 whenever transmit is enabled.
- R2: With fmt_sel=1 (MSB-justified), a word's MSB is sent on the first strobe of its slot, MSB first. The first strobe of a slot is the first one whose sampled ws_in differs from the previous strobe.
- R3: With fmt_sel=0 (standard I2S), the word starts one strobe after the slot begins. When the sample fills the slot, its LSB goes out on the first strobe of the next slot.
- R4: With fmt_sel=2 (LSB-justified), a word's LSB is sent on the last strobe of its slot, and the word occupies the final bits of the slot.
- R5: With lr_pol=0, the left sample travels while ws_in is low. With lr_pol=1, it travels while ws_in is high.
- R6: len_sel selects the sample length: 0 gives 16, 1 gives 8 and 2 gives 24 bits. frame_sel selects the bits per frame: 0 gives 32, 1 gives 48, 2 gives 16 and 3 gives 24. Each slot is half a frame. A sample longer than its slot is sent and received as its top slot-length bits only.
- R7: Slot bits outside the word are driven 0 on transmit and ignored on receive.
- R8: tx_data holds {left, right}, each right-aligned in SAMPLE_W bits. A pair is accepted when tx_valid and tx_ready are both high. Accepted pairs are sent in order, one per frame, each taken at the start of the left word.
- R9: If no pair is waiting when a left word starts, the whole frame is sent as zeros. tx_underrun is then 1 from that point until the next left word start that finds a pair.
- R10: rx_data holds {left, right} in the same layout as tx_data, with uncaptured low bits 0. rx_valid rises on the cycle after the strobe that carries the right word's last bit. It is raised only for a frame whose left word was fully received. A pending pair is held stable until rx_ready, and pairs that complete while it is pending are dropped.
- R11: dir_sel picks the direction. 0 is transmit only, so rx_valid stays 0. 1 is receive only, so sd_out and tx_ready stay 0 and tx_underrun stays 0. 2 is both directions. 3 is neither.
- R12: Nothing is sent or captured before the first word-select change seen after reset. The first strobe after reset only records the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle pulse per serial bit period |
| ws_in | input | 1 | Word-select level, sampled on bit_stb |
| sd_in | input | 1 | Serial data input, sampled on bit_stb |
| sd_out | output | 1 | Serial data output, updated on the cycle after bit_stb |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 MSB-justified, 2 LSB-justified |
| lr_pol | input | 1 | Word-select level that carries the left channel |
| len_sel | input | 2 | Sample length code |
| frame_sel | input | 2 | Bits-per-frame code |
| dir_sel | input | 2 | Direction code |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit pair can be taken |
| tx_data | input | 2*SAMPLE_W | Transmit pair {left, right} |
| tx_underrun | output | 1 | Current frame was zero-filled |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Received pair taken |
| rx_data | output | 2*SAMPLE_W | Received pair {left, right} |

## Verification
Each framing mode is driven with a stream of distinct stereo pairs. The patterns cover a sample equal to the slot, a sample shorter than the slot and a sample longer than the slot. Equal-length samples in I2S framing reveal whether the LSB is carried into the next slot. Short samples in LSB-justified framing reveal whether the word is placed at the right end of the slot. Long samples show the truncation to the top bits. Receive padding is driven with ones, so a capture that strays outside the word shows up as corrupt data. Runs with an inverted polarity would catch swapped channels. A feed that runs dry, a word-select that never toggles, and each direction code show the zero-fill, lock and gating behaviour.

// File: rtl/i2s_serdes_pkg.sv
package i2s_serdes_pkg;

  typedef enum logic [1:0] {
    JUST_I2S = 2'd0,
    JUST_MSB = 2'd1,
    JUST_LSB = 2'd2,
    JUST_RSV = 2'd3
  } just_e;

  typedef enum logic [1:0] {
    DIR_TX   = 2'd0,
    DIR_RX   = 2'd1,
    DIR_BOTH = 2'd2,
    DIR_NONE = 2'd3
  } dir_e;

  function automatic int unsigned sample_bits(input logic [1:0] code);
    case (code)
      2'd1:    return 8;
      2'd2:    return 24;
      default: return 16;
    endcase
  endfunction

  function automatic int unsigned slot_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 24;
      2'd2:    return 8;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/i2s_slot_track.sv
module i2s_slot_track #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_stb,
  input  logic          ws_in,
  input  logic          lr_pol,
  input  logic [1:0]    fmt,
  input  logic [PW-1:0] slot_len,
  input  logic [PW-1:0] word_len,
  output logic          in_word,
  output logic          word_left,
  output logic          word_first,
  output logic          word_last,
  output logic [PW-1:0] word_idx,
  output logic          locked
);
  import i2s_serdes_pkg::*;

  localparam logic [PW-1:0] POS_SAT = '1;

  logic          primed_q, sync_q, ws_q, left_q;
  logic [PW-1:0] pos_q;

  logic          edge_now, left_now, sync_now, ok, e_left;
  logic [PW-1:0] p, d_len, off, e;

  always_comb begin
    edge_now = primed_q && (ws_in != ws_q);
    if (edge_now)             p = '0;
    else if (pos_q == POS_SAT) p = pos_q;
    else                      p = pos_q + 1'b1;
    left_now = (ws_in == lr_pol);
    sync_now = sync_q | edge_now;
    d_len    = (word_len < slot_len) ? word_len : slot_len;
    off      = slot_len - d_len;
    e        = p;
    e_left   = left_now;
    ok       = 1'b0;
    case (fmt)
      JUST_MSB: begin
        e  = p;
        ok = sync_now && (p < d_len);
      end
      JUST_LSB: begin
        e  = p - off;
        ok = sync_now && (p >= off) && (p < slot_len);
      end
      default: begin
        // one-bit delay: first bit of a slot still belongs to the previous word
        if (p == '0) begin
          e      = slot_len - 1'b1;
          e_left = left_q;
          ok     = sync_q && (e < d_len);
        end else begin
          e  = p - 1'b1;
          ok = sync_now && (e < d_len);
        end
      end
    endcase
  end

  assign in_word    = bit_stb && ok;
  assign word_left  = e_left;
  assign word_idx   = e;
  assign word_first = (e == '0);
  assign word_last  = (e == d_len - 1'b1);
  assign locked     = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= 1'b0;
      sync_q   <= 1'b0;
      ws_q     <= 1'b0;
      left_q   <= 1'b0;
      pos_q    <= POS_SAT;
    end else if (bit_stb) begin
      primed_q <= 1'b1;
      ws_q     <= ws_in;
      pos_q    <= p;
      left_q   <= left_now;
      sync_q   <= sync_now;
    end
  end

  // R12: the first strobe after reset can never establish lock
  assert_no_lock_first_R12: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && !primed_q) |=> !locked);

endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane #(
  parameter int W  = 24,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          bit_stb,
  input  logic          in_word,
  input  logic          word_left,
  input  logic          word_first,
  input  logic [PW-1:0] word_idx,
  input  logic [PW-1:0] word_len,
  input  logic          tx_valid,
  input  logic [2*W-1:0] tx_data,
  output logic          tx_ready,
  output logic          sd_out,
  output logic          underrun
);
  logic [2*W-1:0] hold_q, cur_q, src;
  logic           full_q, sd_q, ur_q;
  logic           load, take, bit_val;
  logic [W-1:0]   word;
  logic [PW-1:0]  bidx;

  assign tx_ready = en && !full_q;
  assign take     = tx_valid && tx_ready;
  assign load     = en && in_word && word_left && word_first;

  always_comb begin
    src     = load ? (full_q ? hold_q : '0) : cur_q;
    word    = word_left ? src[2*W-1:W] : src[W-1:0];
    bidx    = word_len - 1'b1 - word_idx;
    bit_val = |(word & (W'(1) << bidx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      cur_q  <= '0;
      full_q <= 1'b0;
      sd_q   <= 1'b0;
      ur_q   <= 1'b0;
    end else begin
      if (bit_stb) sd_q <= en && in_word && bit_val;
      if (load) begin
        cur_q <= full_q ? hold_q : '0;
        ur_q  <= !full_q;
      end
      if (take) hold_q <= tx_data;
      full_q <= (full_q && !load) || take;
    end
  end

  assign sd_out   = sd_q;
  assign underrun = ur_q;

  // R8: a single holding slot, so an accepted pair blocks the next one
  assert_accept_fills_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R9: the flag only changes at a bit strobe
  assert_underrun_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(bit_stb));
  // R11: a disabled transmitter keeps the line low
  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sd_out);

endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane #(
  parameter int W  = 24,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          sd_in,
  input  logic          in_word,
  input  logic          word_left,
  input  logic          word_first,
  input  logic          word_last,
  input  logic [PW-1:0] word_idx,
  input  logic [PW-1:0] word_len,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [2*W-1:0] rx_data
);
  logic [W-1:0]   left_q, right_q, acc_base, acc_n, bit_mask;
  logic           got_left_q, valid_q;
  logic [2*W-1:0] data_q;
  logic [PW-1:0]  bidx;
  logic           cap, emit;

  always_comb begin
    cap      = en && in_word;
    bidx     = word_len - 1'b1 - word_idx;
    bit_mask = W'(1) << bidx;
    acc_base = word_first ? '0 : (word_left ? left_q : right_q);
    acc_n    = sd_in ? (acc_base | bit_mask) : (acc_base & ~bit_mask);
    emit     = cap && !word_left && word_last && got_left_q &&
               (!valid_q || rx_ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q     <= '0;
      right_q    <= '0;
      got_left_q <= 1'b0;
      valid_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      if (valid_q && rx_ready) valid_q <= 1'b0;
      if (cap) begin
        if (word_left) begin
          left_q <= acc_n;
          if (word_last) got_left_q <= 1'b1;
        end else begin
          right_q <= acc_n;
          if (word_last) got_left_q <= 1'b0;
        end
      end
      if (emit) begin
        data_q  <= {left_q, acc_n};
        valid_q <= 1'b1;
      end
    end
  end

  assign rx_valid = valid_q;
  assign rx_data  = data_q;

  // R10: a pending pair stays put until it is taken
  assert_hold_pending_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R11: a disabled receiver never offers a pair
  assert_rx_off_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !rx_valid);

endmodule

// File: rtl/i2s_serdes.sv
module i2s_serdes #(
  parameter int SAMPLE_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_stb,
  input  logic                  ws_in,
  input  logic                  sd_in,
  output logic                  sd_out,
  input  logic [1:0]            fmt_sel,
  input  logic                  lr_pol,
  input  logic [1:0]            len_sel,
  input  logic [1:0]            frame_sel,
  input  logic [1:0]            dir_sel,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [2*SAMPLE_W-1:0] tx_data,
  output logic                  tx_underrun,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [2*SAMPLE_W-1:0] rx_data
);
  import i2s_serdes_pkg::*;

  localparam int PW = $clog2(2 * SAMPLE_W) + 1;

  logic [PW-1:0] word_len, slot_len, word_idx;
  logic          tx_en, rx_en;
  logic          in_word, word_left, word_first, word_last, locked;

  assign word_len = PW'(sample_bits(len_sel));
  assign slot_len = PW'(slot_bits(frame_sel));
  assign tx_en    = (dir_sel == DIR_TX) || (dir_sel == DIR_BOTH);
  assign rx_en    = (dir_sel == DIR_RX) || (dir_sel == DIR_BOTH);

  i2s_slot_track #(.PW(PW)) u_track (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .ws_in(ws_in), .lr_pol(lr_pol),
    .fmt(fmt_sel), .slot_len(slot_len), .word_len(word_len),
    .in_word(in_word), .word_left(word_left), .word_first(word_first),
    .word_last(word_last), .word_idx(word_idx), .locked(locked)
  );

  i2s_tx_lane #(.W(SAMPLE_W), .PW(PW)) u_tx (
    .clk(clk), .rst(rst), .en(tx_en), .bit_stb(bit_stb), .in_word(in_word),
    .word_left(word_left), .word_first(word_first), .word_idx(word_idx),
    .word_len(word_len), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .sd_out(sd_out), .underrun(tx_underrun)
  );

  i2s_rx_lane #(.W(SAMPLE_W), .PW(PW)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .sd_in(sd_in), .in_word(in_word),
    .word_left(word_left), .word_first(word_first), .word_last(word_last),
    .word_idx(word_idx), .word_len(word_len), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  // R12: a received pair can only appear once framing is locked
  assert_pair_after_lock_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> locked);

endmodule

// File: tb/test_i2s_serdes.sv
module test_i2s_serdes;
  localparam int W    = 24;
  localparam int BDIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
  logic [1:0] fmt_sel = 2'd1, len_sel = 2'd0, frame_sel = 2'd0, dir_sel = 2'd2;
  logic lr_pol = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b1;
  logic [2*W-1:0] tx_data = '0;
  logic sd_out, tx_ready, tx_underrun, rx_valid;
  logic [2*W-1:0] rx_data;

  always #2.5 clk = ~clk;

  i2s_serdes #(.SAMPLE_W(W)) i_i2s_serdes (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .ws_in(ws_in), .sd_in(sd_in),
    .sd_out(sd_out), .fmt_sel(fmt_sel), .lr_pol(lr_pol), .len_sel(len_sel),
    .frame_sel(frame_sel), .dir_sel(dir_sel), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_underrun(tx_underrun),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  int checks = 0, fails = 0, rx_stray = 0;
  logic [2*W-1:0] tx_q[$];
  logic [2*W-1:0] rx_q[$];
  bit txrec [0:47];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int blen();
    case (len_sel) 2'd1: return 8; 2'd2: return 24; default: return 16; endcase
  endfunction
  function automatic int slen();
    case (frame_sel) 2'd0: return 16; 2'd1: return 24; 2'd2: return 8; default: return 12; endcase
  endfunction
  function automatic int dlen();
    return (blen() < slen()) ? blen() : slen();
  endfunction
  function automatic logic [2*W-1:0] keep_top(input logic [2*W-1:0] pr);
    logic [W-1:0] m;
    m = W'(((1 << dlen()) - 1) << (blen() - dlen()));
    return {pr[2*W-1:W] & m, pr[W-1:0] & m};
  endfunction
  function automatic logic [2*W-1:0] make_pair(input int k, input int salt);
    logic [W-1:0] a, b, lm;
    lm = W'((1 << blen()) - 1);
    a = W'(k * 24'h1357 + salt * 24'h0F1 + 24'h2468A);
    b = W'(k * 24'h0B3D + salt * 24'h207 + 24'h009F1);
    a = (a & lm) | W'(1 << (blen() - 1));
    b = (b & lm) | W'(1 << (blen() - 1));
    return {a, b};
  endfunction
  // bit m of the frame laid out with no one-bit delay
  function automatic bit frame_bit(input logic [2*W-1:0] pr, input int m, input bit pad);
    int s, l, d, i;
    logic [W-1:0] w;
    s = slen(); l = blen(); d = dlen();
    i = m % s;
    w = (m < s) ? pr[2*W-1:W] : pr[W-1:0];
    if (fmt_sel == 2'd2) return (i >= s - d) ? w[l - 1 - (i - (s - d))] : pad;
    return (i < d) ? w[l - 1 - i] : pad;
  endfunction
  function automatic string mode_req();
    string r;
    r = (fmt_sel == 2'd1) ? "R2" : (fmt_sel == 2'd2) ? "R4" : "R3";
    if (lr_pol) r = {r, " R5"};
    if (len_sel != 2'd0 || frame_sel != 2'd0) r = {r, " R6"};
    return r;
  endfunction

  task automatic decode_frame();
    int s, l, d, k;
    bit pad_bad;
    logic [W-1:0] wd [2];
    logic [2*W-1:0] got, exp;
    s = slen(); l = blen(); d = dlen();
    pad_bad = 1'b0;
    for (int ch = 0; ch < 2; ch++) begin
      wd[ch] = '0;
      for (int i = 0; i < s; i++) begin
        k = -1;
        if (fmt_sel == 2'd2) begin
          if (i >= s - d) k = i - (s - d);
        end else if (i < d) k = i;
        if (k >= 0) wd[ch][l - 1 - k] = txrec[ch * s + i];
        else if (txrec[ch * s + i]) pad_bad = 1'b1;
      end
    end
    got = {wd[0], wd[1]};
    check(!pad_bad, "R7", "nonzero padding bit on sd_out", got, '0);
    if (got != '0) begin
      if (tx_q.size() == 0) begin
        check(1'b0, (dir_sel == 2'd1) ? "R11" : "R8", "unexpected serial pair", got, '0);
      end else begin
        exp = tx_q.pop_front();
        check(got == exp, mode_req(), "serial pair", got, exp);
      end
    end
  endtask

  task automatic run_frames(input int nf, input bit drive_rx, input int ur_exp);
    int s, m;
    bit prev_last;
    logic [2*W-1:0] pr;
    s = slen();
    prev_last = 1'b0;
    for (int f = 0; f < nf; f++) begin
      pr = drive_rx && (f < nf - 1) ? make_pair(f, 7) : '0;
      if (drive_rx && f >= 1 && f < nf - 1 && (dir_sel == 2'd1 || dir_sel == 2'd2))
        rx_q.push_back(keep_top(pr));
      for (int j = 0; j < 2 * s; j++) begin
        @(negedge clk);
        ws_in = (j < s) ? lr_pol : !lr_pol;
        m = (fmt_sel == 2'd0 || fmt_sel == 2'd3) ? j - 1 : j;
        sd_in = (m < 0) ? prev_last : frame_bit(pr, m, 1'b1);
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        if (m < 0) begin
          txrec[2 * s - 1] = sd_out;
          if (f > 0) decode_frame();
        end else begin
          txrec[m] = sd_out;
          if (m == 2 * s - 1) decode_frame();
        end
        if (f == 2 && j == s && ur_exp >= 0)
          check(tx_underrun == ur_exp[0], "R9", "underrun flag mid-run",
                2*W'(tx_underrun), 2*W'(ur_exp));
        repeat (BDIV - 2) @(negedge clk);
      end
      prev_last = frame_bit(pr, 2 * s - 1, 1'b1);
    end
  endtask

  task automatic feed(input int np);
    logic [2*W-1:0] v;
    for (int k = 0; k < np; k++) begin
      v = make_pair(k, 3);
      tx_data = v;
      tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      tx_q.push_back(keep_top(v));
      @(negedge clk);
    end
    tx_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] f, input logic p, input logic [1:0] l,
                          input logic [1:0] fr, input logic [1:0] d);
    @(negedge clk);
    rst = 1'b1; tx_valid = 1'b0; bit_stb = 1'b0; ws_in = 1'b0; sd_in = 1'b0;
    fmt_sel = f; lr_pol = p; len_sel = l; frame_sel = fr; dir_sel = d;
    tx_q.delete(); rx_q.delete(); rx_stray = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic stream_test(input logic [1:0] f, input logic p, input logic [1:0] l,
                             input logic [1:0] fr);
    do_reset(f, p, l, fr, 2'd2);
    fork
      feed(4);
      run_frames(7, 1'b1, 0);
    join
    check(tx_q.size() == 0, "R8", "transmit pairs left unsent", 2*W'(tx_q.size()), '0);
    check(rx_q.size() == 0, "R10", "received pairs missing", 2*W'(rx_q.size()), '0);
    check(tx_underrun == 1'b1, "R9", "underrun after feed ran dry", 2*W'(tx_underrun), 1);
  endtask

  always @(negedge clk) begin
    if (!rst && rx_valid && rx_ready) begin
      if (rx_q.size() > 0) begin
        logic [2*W-1:0] e;
        e = rx_q.pop_front();
        check(rx_data == e, {"R10 R7 ", mode_req()}, "received pair", rx_data, e);
      end else begin
        rx_stray++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R0", "watchdog expired", '0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(2'd1, 1'b0, 2'd0, 2'd0, 2'd2);
    check(sd_out == 1'b0, "R1", "sd_out after reset", 2*W'(sd_out), '0);
    check(rx_valid == 1'b0, "R1", "rx_valid after reset", 2*W'(rx_valid), '0);
    check(tx_underrun == 1'b0, "R1", "tx_underrun after reset", 2*W'(tx_underrun), '0);
    check(tx_ready == 1'b1, "R1", "tx_ready after reset", 2*W'(tx_ready), 1);

    stream_test(2'd1, 1'b0, 2'd0, 2'd0);   // MSB, 16 in 16
    stream_test(2'd0, 1'b0, 2'd0, 2'd0);   // I2S, 16 in 16, LSB spills
    stream_test(2'd2, 1'b1, 2'd0, 2'd1);   // LSB, 16 in 24, inverted select
    stream_test(2'd0, 1'b1, 2'd2, 2'd1);   // I2S, 24 in 24
    stream_test(2'd1, 1'b0, 2'd1, 2'd3);   // MSB, 8 in 12
    stream_test(2'd2, 1'b0, 2'd1, 2'd0);   // LSB, 8 in 16
    stream_test(2'd1, 1'b1, 2'd2, 2'd2);   // MSB, 24 truncated to 8
    stream_test(2'd2, 1'b0, 2'd2, 2'd2);   // LSB, 24 truncated to 8

    // R11 transmit only: receive side stays silent
    do_reset(2'd0, 1'b0, 2'd0, 2'd0, 2'd0);
    fork
      feed(3);
      run_frames(6, 1'b1, 0);
    join
    check(rx_stray == 0, "R11", "rx_valid in transmit-only mode", 2*W'(rx_stray), '0);
    check(tx_q.size() == 0, "R11", "transmit-only pairs unsent", 2*W'(tx_q.size()), '0);

    // R11 receive only: no transmit activity
    do_reset(2'd1, 1'b0, 2'd0, 2'd0, 2'd1);
    check(tx_ready == 1'b0, "R11", "tx_ready in receive-only mode", 2*W'(tx_ready), '0);
    run_frames(6, 1'b1, 0);
    check(rx_q.size() == 0, "R11", "receive-only pairs missing", 2*W'(rx_q.size()), '0);
    check(tx_underrun == 1'b0, "R11", "underrun in receive-only mode", 2*W'(tx_underrun), '0);

    // R9 no feed at all: zero frames with underrun raised
    do_reset(2'd1, 1'b0, 2'd0, 2'd0, 2'd0);
    run_frames(4, 1'b0, 1);

    // R11 neither direction
    do_reset(2'd1, 1'b0, 2'd0, 2'd0, 2'd3);
    check(tx_ready == 1'b0, "R11", "tx_ready with both directions off", 2*W'(tx_ready), '0);
    run_frames(4, 1'b1, 0);
    check(rx_stray == 0, "R11", "rx_valid with both directions off", 2*W'(rx_stray), '0);

    // R12 word select never changes: nothing sent, loaded or captured
    do_reset(2'd1, 1'b0, 2'd0, 2'd0, 2'd2);
    fork
      feed(1);
    join
    begin
      bit any_out;
      any_out = 1'b0;
      for (int n = 0; n < 40; n++) begin
        @(negedge clk);
        ws_in = 1'b0; sd_in = 1'b1; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        if (sd_out) any_out = 1'b1;
        repeat (BDIV - 2) @(negedge clk);
      end
      check(!any_out, "R12", "sd_out before first select change", 2*W'(any_out), '0);
      check(rx_stray == 0, "R12", "rx_valid before first select change", 2*W'(rx_stray), '0);
      check(tx_underrun == 1'b0, "R12", "load before first select change", 2*W'(tx_underrun), '0);
      check(tx_ready == 1'b0, "R12", "held pair still waiting", 2*W'(tx_ready), '0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule